// File: doc/BRIEF.md
# Pulse-Swallow Programmable Feedback Divider

This block divides a fast oscillator-side clock by a programmable ratio P·N + A. It feeds the comparison input of a phase detector in a frequency synthesizer loop. The block contains a synthesizable digital model of a dual-modulus prescaler that divides by P or P+1. It also has a main counter N of 11 bits and a swallow counter A of 7 bits. The swallow counter holds the prescaler at P+1 for the first A prescaler cycles of each output period. The prescaler then runs at P for the remaining N−A cycles. The result is a fine-grained total ratio, not a plain multiple of P.

A single select bit picks the prescaler pair. With the default parameter (`PSC_LOG2 = 3`), select 1 gives 8/9 and select 0 gives 16/17. With `PSC_LOG2 = 6` the same bit chooses between 64/65 and 128/129. The main count, the swallow count and the select bit are sampled only at a period boundary. The block therefore never truncates a period. A power-enable input puts the divider into an idle state in which it makes no comparison pulses.

Top module: `pswallow_fbdiv`

## Requirements
- R1: With main count N (3..2047) and swallow count A (0 ≤ A < N), consecutive `fp_o` pulses are exactly P·N + A input clocks apart. P is 2^PSC_LOG2 when `sel_i` = 1 and 2^(PSC_LOG2+1) when `sel_i` = 0, which is 8 and 16 with the defaults.
- R2: `fp_o` is high for exactly one input clock cycle per period.
- R3: `mod_hi_o` is high for exactly A·(P+1) input clocks per period. These clocks start in the cycle in which `fp_o` is high. `mod_hi_o` is low for the rest of the period and in the cycle just before each pulse.
- R4: With A = 0, the spacing is exactly P·N and `mod_hi_o` stays low.
- R5: A change of `n_i`, `a_i` or `sel_i` in the middle of a period does not alter that period. The new values govern the period that starts at the next pulse.
- R6: An `n_i` value below 3 is treated as 3.
- R7: An `a_i` value not below the effective N is treated as N−1.
- R8: While `pwr_en_i` is low, `fp_o` and `mod_hi_o` stay low. After reset release or power-enable rise, the first `fp_o` appears in the (P·N + A + 1)-th cycle, counting the first clock edge that sees `pwr_en_i` high.
- R9: While `rst_ni` is low, `fp_o` and `mod_hi_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Oscillator-side input clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| pwr_en_i | input | 1 | 1 = divide, 0 = idle power-saving state |
| n_i | input | N_W | Main counter setting N |
| a_i | input | A_W | Swallow counter setting A |
| sel_i | input | 1 | Prescaler pair select: 1 = P base, 0 = P doubled |
| fp_o | output | 1 | One-cycle comparison pulse per output period |
| mod_hi_o | output | 1 | Modulus control: 1 requests P+1, 0 requests P |

## Verification
Any wrong count in the main counter, the swallow counter or the prescaler changes the measured pulse spacing in the very next period. A swallow count that is off by one shifts the spacing by one clock. A prescaler length error shifts it by N or by A. A swallow error also changes the number of `mod_hi_o` cycles within that same period, so the bench compares both quantities for every monitored period. A boundary-capture fault, such as loading new settings mid-period, shows up as one period whose spacing matches neither the old setting nor the new one. It appears right after an input change.

// File: rtl/pswallow_pkg.sv
package pswallow_pkg;
  localparam int unsigned MIN_MAIN = 3;

  typedef enum logic {
    SEL_DOUBLE = 1'b0,
    SEL_BASE   = 1'b1
  } band_sel_e;
endpackage

// File: rtl/psw_cfg.sv
module psw_cfg #(
  parameter int unsigned N_W = 11,
  parameter int unsigned A_W = 7
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           take_i,
  input  logic [N_W-1:0] n_i,
  input  logic [A_W-1:0] a_i,
  input  logic           sel_i,
  output logic [N_W-1:0] n_ld_o,
  output logic [A_W-1:0] a_ld_o,
  output logic           sel_nx_o
);
  import pswallow_pkg::*;

  logic [N_W-1:0] n_eff;
  logic [N_W-1:0] a_ext;
  logic           sel_q;

  // clamp illegal settings so a period is always well formed
  always_comb begin
    n_eff = (n_i < N_W'(MIN_MAIN)) ? N_W'(MIN_MAIN) : n_i;
    a_ext = N_W'(a_i);
  end

  assign n_ld_o   = n_eff;
  assign a_ld_o   = (a_ext >= n_eff) ? A_W'(n_eff - N_W'(1)) : a_i;
  assign sel_nx_o = take_i ? sel_i : sel_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     sel_q <= SEL_BASE;
    else if (take_i) sel_q <= sel_i;
  end
endmodule

// File: rtl/psw_prescaler.sv
module psw_prescaler #(
  parameter int unsigned PSC_LOG2 = 3
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  logic load_i,
  input  logic sel_nx_i,
  input  logic mod_nx_i,
  output logic tick_o
);
  import pswallow_pkg::*;

  localparam int unsigned CW = PSC_LOG2 + 2;
  localparam logic [CW-1:0] P_BASE = CW'(1) << PSC_LOG2;
  localparam logic [CW-1:0] P_DBL  = CW'(1) << (PSC_LOG2 + 1);

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] len_m1;

  // length of the prescaler cycle about to start
  always_comb begin
    len_m1 = ((sel_nx_i == SEL_BASE) ? P_BASE : P_DBL) + CW'(mod_nx_i) - CW'(1);
  end

  assign tick_o = en_i && (cnt_q == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (load_i) cnt_q <= len_m1;
    else if (en_i)   cnt_q <= (cnt_q == '0) ? len_m1 : cnt_q - CW'(1);
  end
endmodule

// File: rtl/psw_swallow.sv
module psw_swallow #(
  parameter int unsigned N_W = 11,
  parameter int unsigned A_W = 7
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           take_i,
  input  logic           tick_i,
  input  logic [N_W-1:0] n_ld_i,
  input  logic [A_W-1:0] a_ld_i,
  output logic           a_nz_o,
  output logic           mod_nx_o,
  output logic           last_o
);
  logic [N_W-1:0] n_q;
  logic [A_W-1:0] a_q;
  logic [A_W-1:0] a_nx;

  always_comb begin
    if (take_i)                   a_nx = a_ld_i;
    else if (tick_i && a_q != '0) a_nx = a_q - A_W'(1);
    else                          a_nx = a_q;
  end

  assign mod_nx_o = (a_nx != '0);
  assign a_nz_o   = (a_q != '0);
  assign last_o   = (n_q == N_W'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      n_q <= '0;
      a_q <= '0;
    end else begin
      a_q <= a_nx;
      if (take_i)      n_q <= n_ld_i;
      else if (tick_i) n_q <= n_q - N_W'(1);
    end
  end
endmodule

// File: rtl/pswallow_fbdiv.sv
module pswallow_fbdiv #(
  parameter int unsigned N_W      = 11,
  parameter int unsigned A_W      = 7,
  parameter int unsigned PSC_LOG2 = 3
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           pwr_en_i,
  input  logic [N_W-1:0] n_i,
  input  logic [A_W-1:0] a_i,
  input  logic           sel_i,
  output logic           fp_o,
  output logic           mod_hi_o
);
  logic           run_q, fp_q;
  logic           en, start, tick, last, wrap, take;
  logic [N_W-1:0] n_ld;
  logic [A_W-1:0] a_ld;
  logic           sel_nx, mod_nx, a_nz;

  assign en    = run_q && pwr_en_i;
  assign start = pwr_en_i && !run_q;
  assign wrap  = tick && last;
  assign take  = start || wrap;

  psw_cfg #(.N_W(N_W), .A_W(A_W)) u_cfg (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .take_i   (take),
    .n_i      (n_i),
    .a_i      (a_i),
    .sel_i    (sel_i),
    .n_ld_o   (n_ld),
    .a_ld_o   (a_ld),
    .sel_nx_o (sel_nx)
  );

  psw_swallow #(.N_W(N_W), .A_W(A_W)) u_swl (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .take_i   (take),
    .tick_i   (tick),
    .n_ld_i   (n_ld),
    .a_ld_i   (a_ld),
    .a_nz_o   (a_nz),
    .mod_nx_o (mod_nx),
    .last_o   (last)
  );

  psw_prescaler #(.PSC_LOG2(PSC_LOG2)) u_psc (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .en_i     (en),
    .load_i   (start),
    .sel_nx_i (sel_nx),
    .mod_nx_i (mod_nx),
    .tick_o   (tick)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q <= 1'b0;
      fp_q  <= 1'b0;
    end else begin
      run_q <= pwr_en_i;
      fp_q  <= wrap;
    end
  end

  assign fp_o     = fp_q;
  assign mod_hi_o = en && a_nz;
endmodule

// File: rtl/pswallow_fbdiv_chk.sv
module pswallow_fbdiv_chk #(
  parameter int unsigned N_W      = 11,
  parameter int unsigned PSC_LOG2 = 3
) (
  input logic clk_i,
  input logic rst_ni,
  input logic pwr_en_i,
  input logic fp_o,
  input logic mod_hi_o
);
  import pswallow_pkg::*;

  localparam int unsigned GW = N_W + PSC_LOG2 + 3;
  localparam logic [GW-1:0] MIN_GAP = GW'(MIN_MAIN) << PSC_LOG2;

  logic [GW-1:0] gap_q;
  logic          seen_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      gap_q  <= '0;
      seen_q <= 1'b0;
    end else begin
      if (fp_o)             gap_q <= GW'(1);
      else if (~&gap_q)     gap_q <= gap_q + GW'(1);
      if (!pwr_en_i)        seen_q <= 1'b0;
      else if (fp_o)        seen_q <= 1'b1;
    end
  end

  assert_fp_single_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fp_o |=> !fp_o);

  assert_no_fp_idle_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pwr_en_i |=> !fp_o);

  assert_no_mod_idle_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pwr_en_i |-> !mod_hi_o);

  assert_min_gap_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fp_o && seen_q && pwr_en_i) |-> (gap_q >= MIN_GAP));

  assert_mod_low_before_fp_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(fp_o) |-> !$past(mod_hi_o));
endmodule

bind pswallow_fbdiv pswallow_fbdiv_chk #(.N_W(N_W), .PSC_LOG2(PSC_LOG2)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .pwr_en_i (pwr_en_i),
  .fp_o     (fp_o),
  .mod_hi_o (mod_hi_o)
);

// File: tb/pswallow_fbdiv_test.sv
module pswallow_fbdiv_test;
  localparam int N_W = 11;
  localparam int A_W = 7;

  logic           clk_i = 1'b0;
  logic           rst_ni = 1'b0;
  logic           pwr_en_i = 1'b1;
  logic [N_W-1:0] n_i = 11'd5;
  logic [A_W-1:0] a_i = 7'd2;
  logic           sel_i = 1'b1;
  logic           fp_o, mod_hi_o;

  pswallow_fbdiv #(.N_W(N_W), .A_W(A_W), .PSC_LOG2(3)) uut (
    .clk_i(clk_i), .rst_ni(rst_ni), .pwr_en_i(pwr_en_i),
    .n_i(n_i), .a_i(a_i), .sel_i(sel_i),
    .fp_o(fp_o), .mod_hi_o(mod_hi_o)
  );

  always #10 clk_i = ~clk_i;

  typedef struct {int gap; int hi; string req;} exp_t;
  exp_t sb_q[$];
  int   n_checks = 0, n_fail = 0;
  int   mon_gap = 0, mon_hi = 0;
  bit   armed = 0, prev_fp = 0;

  task automatic chk(string req, string what, int act, int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // expected spacing and high count from the requirement rules
  function automatic int eff_n(int n);
    return (n < 3) ? 3 : n;
  endfunction
  function automatic int eff_a(int n, int a);
    return (a >= eff_n(n)) ? eff_n(n) - 1 : a;
  endfunction
  function automatic int p_of(bit s);
    return s ? 8 : 16;
  endfunction

  // monitor: measure each period and compare with the scoreboard
  always @(negedge clk_i) begin
    if (rst_ni) begin
      if (!pwr_en_i) armed = 0;
      if (fp_o) begin
        chk("R2", "pulse width", prev_fp ? 2 : 1, 1);
        if (armed && sb_q.size() > 0) begin
          exp_t e;
          e = sb_q.pop_front();
          chk(e.req, "period spacing", mon_gap, e.gap);
          chk(e.req, "mod high cycles", mon_hi, e.hi);
        end
        mon_gap = 1;
        mon_hi  = mod_hi_o ? 1 : 0;
        armed   = pwr_en_i;
      end else begin
        mon_gap++;
        mon_hi += mod_hi_o ? 1 : 0;
      end
      prev_fp = fp_o;
    end
  end

  task automatic wait_fp();
    do @(negedge clk_i); while (!fp_o);
  endtask

  task automatic push_exp(int n, int a, bit s, string req);
    exp_t e;
    e.gap = p_of(s) * eff_n(n) + eff_a(n, a);
    e.hi  = eff_a(n, a) * (p_of(s) + 1);
    e.req = req;
    sb_q.push_back(e);
  endtask

  task automatic drain();
    while (sb_q.size() != 0) @(negedge clk_i);
  endtask

  task automatic run_cfg(int n, int a, bit s, string req);
    @(negedge clk_i);
    n_i = N_W'(n); a_i = A_W'(a); sel_i = s;
    wait_fp();
    @(posedge clk_i);
    push_exp(n, a, s, req);
    drain();
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    n_fail++;
    $display("FAIL watchdog R1: actual hung expected finish");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    int cnt;
    int ones;
    // R9: reset state
    repeat (3) @(negedge clk_i);
    chk("R9", "fp in reset", int'(fp_o), 0);
    chk("R9", "mod in reset", int'(mod_hi_o), 0);

    // R8: first pulse latency after reset release, N=5 A=2 P=8 -> 42+1
    rst_ni = 1'b1;
    cnt = 0;
    do begin @(negedge clk_i); cnt++; end while (!fp_o && cnt < 1000);
    chk("R8", "startup latency", cnt, 43);
    @(posedge clk_i);
    push_exp(5, 2, 1'b1, "R1");
    drain();

    run_cfg(5, 2, 1'b0, "R1");
    run_cfg(3, 2, 1'b1, "R3");
    run_cfg(10, 0, 1'b1, "R4");
    run_cfg(10, 0, 1'b0, "R4");
    run_cfg(200, 127, 1'b0, "R3");
    run_cfg(2047, 127, 1'b1, "R1");
    run_cfg(1, 0, 1'b1, "R6");
    run_cfg(0, 1, 1'b0, "R6");
    run_cfg(4, 9, 1'b1, "R7");
    run_cfg(10, 10, 1'b1, "R7");

    // R5: mid-period change leaves the running period alone
    @(negedge clk_i);
    n_i = 11'd20; a_i = 7'd3; sel_i = 1'b1;
    wait_fp();
    @(posedge clk_i);
    push_exp(20, 3, 1'b1, "R5");
    repeat (10) @(negedge clk_i);
    n_i = 11'd7; a_i = 7'd5; sel_i = 1'b0;
    drain();
    push_exp(7, 5, 1'b0, "R5");
    drain();

    // R8: idle state, then resume
    @(negedge clk_i);
    pwr_en_i = 1'b0;
    n_i = 11'd5; a_i = 7'd2; sel_i = 1'b1;
    ones = 0;
    for (int i = 0; i < 300; i++) begin
      @(negedge clk_i);
      ones += (fp_o ? 1 : 0) + (mod_hi_o ? 1 : 0);
    end
    chk("R8", "activity while idle", ones, 0);
    pwr_en_i = 1'b1;
    cnt = 0;
    do begin @(negedge clk_i); cnt++; end while (!fp_o && cnt < 1000);
    chk("R8", "resume latency", cnt, 43);
    @(posedge clk_i);
    push_exp(5, 2, 1'b1, "R8");
    drain();

    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule